// File: doc/BRIEF.md
# Iterative Floating-Point Mantissa Divider

This unit divides one unpacked floating-point value by another. Each operand is given as a class code, a sign bit, a signed unbiased exponent and a normalized mantissa `1.f`, where the hidden one is the top bit. A single cycle with `start` high while the unit is idle hands over both operands. If either operand is NaN, infinity or zero, the unit settles the result in one cycle through a fixed priority of cases and may raise an invalid-operation or divide-by-zero flag.

When both operands are finite and nonzero, the unit runs a restoring shift-and-subtract loop that yields one quotient bit per clock. A single trial subtraction in the setup cycle finds the normalization shift. That same cycle fixes the exponent and the leading quotient bit, so the exponent is final before the loop starts. The quotient carries two bits beyond the stored mantissa, for guard and round. A sticky bit reports whether the final remainder is nonzero. The result is left unrounded and unpacked, and a downstream rounder consumes it.

Top module: `fpdiv_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit returns to idle. After that edge, `busy`, `done`, `flag_invalid` and `flag_divzero` are all 0 and `q_cls` is 0.
- R2: Class codes are 0 for zero, 1 for a finite nonzero number, 2 for infinity, 3 for a quiet NaN and 4 for a signalling NaN. If either operand is a NaN, the result is the operand with the larger class code, and the divisor wins a tie. The result keeps that operand's class, sign and exponent, and its mantissa gets two zero bits appended. `flag_invalid` is set.
- R3: Infinity divided by infinity gives the default NaN, and so does zero divided by zero. The default NaN has class 3, sign 0, exponent 0 and a mantissa with only the top bit set. `flag_invalid` is set.
- R4: Infinity divided by a non-NaN that is not infinity returns the dividend unchanged, with two zero bits appended to its mantissa and no flag. Zero divided by a non-NaN that is not zero behaves the same way.
- R5: A finite nonzero value divided by infinity gives class 0 with sign equal to the XOR of the operand signs, and zero exponent and mantissa. No flag is raised.
- R6: A finite nonzero value divided by zero gives class 2 with sign equal to the XOR of the operand signs. `flag_divzero` is set and `flag_invalid` is clear.
- R7: Counting the edge that accepts a special-case start as edge 0, `done` is high for the cycle after edge 0 and `busy` never rises.
- R8: When both operands have class 1, the result has class 1 and the XOR sign. Its exponent is `num_exp - den_exp` when `num_mant >= den_mant`, and `num_exp - den_exp - 1` otherwise.
- R9: The result mantissa `q_mant` has QW = MANT_W + 2 bits and its top bit is always 1. It equals floor(num_mant * 2^(QW-1) / den_mant) when `num_mant >= den_mant`, and floor(num_mant * 2^QW / den_mant) otherwise.
- R10: `q_sticky` is 1 exactly when the remainder of the R9 division is nonzero. Special-case results have `q_sticky` = 0.
- R11: For a normal division, counting the accepting edge as edge 0, `busy` is high from edge 0 to edge QW-1. `done` is high for the single cycle after edge QW-1. The loop never stops early.
- R12: A `start` pulse while `busy` is high is ignored. It produces no extra `done` and does not change the result of the division in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| num_cls | input | 3 | Dividend class code |
| num_sign | input | 1 | Dividend sign |
| num_exp | input | EXP_W | Dividend exponent, signed |
| num_mant | input | MANT_W | Dividend mantissa, hidden bit on top |
| den_cls | input | 3 | Divisor class code |
| den_sign | input | 1 | Divisor sign |
| den_exp | input | EXP_W | Divisor exponent, signed |
| den_mant | input | MANT_W | Divisor mantissa, hidden bit on top |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle result strobe |
| q_cls | output | 3 | Result class code |
| q_sign | output | 1 | Result sign |
| q_exp | output | EXP_W+2 | Result exponent, signed |
| q_mant | output | MANT_W+2 | Result mantissa with guard and round bits |
| q_sticky | output | 1 | Nonzero final remainder |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_divzero | output | 1 | Divide-by-zero flag |

## Verification
The bound checker watches the handshake on every cycle. It confirms that a special-case start finishes in one cycle and that a normal start raises `busy`, and its cycle counter checks that `busy` lasts exactly QW-1 cycles. It also checks that the exponent and class hold steady while `busy` is high, that every finite result has its top mantissa bit set, and that each flag comes with the matching result class. The bench scenarios are the only place where the quotient bits, the sticky bit, the exponent adjustment and the NaN selection order are compared against a reference computed by integer division. The same goes for proof that a `start` raised during iteration leaves the result unchanged.

// File: rtl/fpdiv_pkg.sv
// Shared types for the floating-point divider.
// Assumes class codes are ordered so that a larger code wins NaN selection.
package fpdiv_pkg;
    typedef enum logic [2:0] {
        FC_ZERO = 3'd0,
        FC_NUM  = 3'd1,
        FC_INF  = 3'd2,
        FC_QNAN = 3'd3,
        FC_SNAN = 3'd4
    } fclass_e;

    function automatic logic cls_is_nan(fclass_e c);
        return (c == FC_QNAN) || (c == FC_SNAN);
    endfunction
endpackage

// File: rtl/fpdiv_special.sv
// Combinational resolver for operand classes that need no iteration.
// Assumes: class codes from fpdiv_pkg; the result sign for the normal path
// is also produced here (XOR of operand signs) so the top can use it.
module fpdiv_special
    import fpdiv_pkg::*;
#(
    parameter int MANT_W = 24,
    parameter int GR_W   = 2,
    parameter int EXP_W  = 10
) (
    input  fclass_e                 a_cls,
    input  logic                    a_sign,
    input  logic [EXP_W-1:0]        a_exp,
    input  logic [MANT_W-1:0]       a_mant,
    input  fclass_e                 b_cls,
    input  logic                    b_sign,
    input  logic [EXP_W-1:0]        b_exp,
    input  logic [MANT_W-1:0]       b_mant,
    output logic                    special,
    output fclass_e                 r_cls,
    output logic                    r_sign,
    output logic [EXP_W+1:0]        r_exp,
    output logic [MANT_W+GR_W-1:0]  r_mant,
    output logic                    r_inv,
    output logic                    r_dz
);
    localparam int QW = MANT_W + GR_W;
    localparam logic [QW-1:0] DFLT_NAN_MANT = {1'b1, {(QW-1){1'b0}}};

    logic sx;
    assign sx = a_sign ^ b_sign;

    // Priority chain: NaN, infinite dividend, zero dividend, then divisor class.
    always_comb begin
        special = 1'b1;
        r_cls   = a_cls;
        r_sign  = a_sign;
        r_exp   = {{2{a_exp[EXP_W-1]}}, a_exp};
        r_mant  = {a_mant, {GR_W{1'b0}}};
        r_inv   = 1'b0;
        r_dz    = 1'b0;
        if (cls_is_nan(a_cls) || cls_is_nan(b_cls)) begin
            r_inv = 1'b1;
            if (!(a_cls > b_cls)) begin
                r_cls  = b_cls;
                r_sign = b_sign;
                r_exp  = {{2{b_exp[EXP_W-1]}}, b_exp};
                r_mant = {b_mant, {GR_W{1'b0}}};
            end
        end else if (a_cls == FC_INF || a_cls == FC_ZERO) begin
            if (b_cls == a_cls) begin
                r_inv  = 1'b1;
                r_cls  = FC_QNAN;
                r_sign = 1'b0;
                r_exp  = '0;
                r_mant = DFLT_NAN_MANT;
            end
        end else if (b_cls == FC_INF) begin
            r_cls  = FC_ZERO;
            r_sign = sx;
            r_exp  = '0;
            r_mant = '0;
        end else if (b_cls == FC_ZERO) begin
            r_cls  = FC_INF;
            r_sign = sx;
            r_exp  = '0;
            r_mant = '0;
            r_dz   = 1'b1;
        end else begin
            special = 1'b0;
            r_cls   = FC_NUM;
            r_sign  = sx;
        end
    end
endmodule

// File: rtl/fpdiv_iter.sv
// Restoring mantissa divider, one quotient bit per clock.
// Assumes both mantissas have their top bit set. The setup cycle performs a
// trial subtraction that fixes the leading bit (always 1) and the shift.
module fpdiv_iter #(
    parameter int MANT_W = 24,
    parameter int QW     = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MANT_W-1:0] x_mant,
    input  logic [MANT_W-1:0] y_mant,
    output logic              short_lead,
    output logic              busy,
    output logic              fin,
    output logic [QW-1:0]     quo,
    output logic              sticky
);
    localparam int RW = MANT_W + 1;
    localparam int CW = $clog2(QW);
    localparam logic [CW-1:0] ITERS = CW'(QW - 1);

    logic [RW-1:0] x_ext, y_ext, seed, rem, y_reg, shifted, rem_nx;
    logic [RW:0]   trial, diff;
    logic          take;
    logic [CW-1:0] cnt;

    // Setup: trial X-Y decides whether the first step uses X or 2X.
    always_comb begin
        x_ext      = {1'b0, x_mant};
        y_ext      = {1'b0, y_mant};
        trial      = {1'b0, x_ext} - {1'b0, y_ext};
        short_lead = trial[RW];
        seed       = short_lead ? ({x_mant, 1'b0} - y_ext) : trial[RW-1:0];
    end

    // Iteration step: shift remainder, subtract divisor, keep on no borrow.
    always_comb begin
        shifted = {rem[RW-2:0], 1'b0};
        diff    = {1'b0, shifted} - {1'b0, y_reg};
        take    = ~diff[RW];
        rem_nx  = take ? diff[RW-1:0] : shifted;
    end

    // Remainder, quotient shift register and fixed iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            fin    <= 1'b0;
            cnt    <= '0;
            rem    <= '0;
            y_reg  <= '0;
            quo    <= '0;
            sticky <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                y_reg <= y_ext;
                rem   <= seed;
                quo   <= QW'(1);
                cnt   <= ITERS;
                busy  <= 1'b1;
            end else if (busy) begin
                rem <= rem_nx;
                quo <= {quo[QW-2:0], take};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy   <= 1'b0;
                    fin    <= 1'b1;
                    sticky <= |rem_nx;
                end
            end
        end
    end
endmodule

// File: rtl/fpdiv_unit.sv
// Top of the divider: start/busy/done handshake, special-case results and
// exponent formation. Assumes inputs are valid in the cycle start is high.
module fpdiv_unit
    import fpdiv_pkg::*;
#(
    parameter int MANT_W = 24,
    parameter int GR_W   = 2,
    parameter int EXP_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2:0]              num_cls,
    input  logic                    num_sign,
    input  logic [EXP_W-1:0]        num_exp,
    input  logic [MANT_W-1:0]       num_mant,
    input  logic [2:0]              den_cls,
    input  logic                    den_sign,
    input  logic [EXP_W-1:0]        den_exp,
    input  logic [MANT_W-1:0]       den_mant,
    output logic                    busy,
    output logic                    done,
    output logic [2:0]              q_cls,
    output logic                    q_sign,
    output logic [EXP_W+1:0]        q_exp,
    output logic [MANT_W+GR_W-1:0]  q_mant,
    output logic                    q_sticky,
    output logic                    flag_invalid,
    output logic                    flag_divzero
);
    localparam int QW = MANT_W + GR_W;
    localparam int XW = EXP_W + 2;

    fclass_e          sp_cls;
    logic             sp_special, sp_sign, sp_inv, sp_dz;
    logic [XW-1:0]    sp_exp, norm_exp;
    logic [QW-1:0]    sp_mant, core_quo, hold_mant;
    logic             core_short, core_busy, core_fin, core_sticky;
    logic             accept, use_core, spec_done;
    fclass_e          cls_q;

    assign accept = start & ~core_busy;

    fpdiv_special #(.MANT_W(MANT_W), .GR_W(GR_W), .EXP_W(EXP_W)) i_special (
        .a_cls   (fclass_e'(num_cls)),
        .a_sign  (num_sign),
        .a_exp   (num_exp),
        .a_mant  (num_mant),
        .b_cls   (fclass_e'(den_cls)),
        .b_sign  (den_sign),
        .b_exp   (den_exp),
        .b_mant  (den_mant),
        .special (sp_special),
        .r_cls   (sp_cls),
        .r_sign  (sp_sign),
        .r_exp   (sp_exp),
        .r_mant  (sp_mant),
        .r_inv   (sp_inv),
        .r_dz    (sp_dz)
    );

    fpdiv_iter #(.MANT_W(MANT_W), .QW(QW)) i_iter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept & ~sp_special),
        .x_mant     (num_mant),
        .y_mant     (den_mant),
        .short_lead (core_short),
        .busy       (core_busy),
        .fin        (core_fin),
        .quo        (core_quo),
        .sticky     (core_sticky)
    );

    // Final exponent: difference, less one when the trial subtraction borrowed.
    always_comb begin
        norm_exp = {{2{num_exp[EXP_W-1]}}, num_exp}
                 - {{2{den_exp[EXP_W-1]}}, den_exp}
                 - XW'(core_short);
    end

    // Capture class, sign, exponent and flags on every accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q        <= FC_ZERO;
            q_sign       <= 1'b0;
            q_exp        <= '0;
            hold_mant    <= '0;
            use_core     <= 1'b0;
            flag_invalid <= 1'b0;
            flag_divzero <= 1'b0;
            spec_done    <= 1'b0;
        end else begin
            spec_done <= 1'b0;
            if (accept) begin
                cls_q        <= sp_cls;
                q_sign       <= sp_sign;
                q_exp        <= sp_special ? sp_exp : norm_exp;
                hold_mant    <= sp_mant;
                use_core     <= ~sp_special;
                flag_invalid <= sp_inv;
                flag_divzero <= sp_dz;
                spec_done    <= sp_special;
            end
        end
    end

    assign q_cls    = cls_q;
    assign busy     = core_busy;
    assign done     = spec_done | core_fin;
    assign q_mant   = use_core ? core_quo : hold_mant;
    assign q_sticky = use_core & core_sticky;
endmodule

// File: rtl/fpdiv_unit_chk.sv
// Cycle-level checks on the divider's handshake and result invariants.
// Assumes it is bound to fpdiv_unit; observes ports only.
module fpdiv_unit_chk #(
    parameter int MANT_W = 24,
    parameter int GR_W   = 2,
    parameter int EXP_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [2:0]              num_cls,
    input logic [2:0]              den_cls,
    input logic                    busy,
    input logic                    done,
    input logic [2:0]              q_cls,
    input logic [EXP_W+1:0]        q_exp,
    input logic [MANT_W+GR_W-1:0]  q_mant,
    input logic                    flag_invalid,
    input logic                    flag_divzero
);
    localparam int QW = MANT_W + GR_W;
    localparam int BW = $clog2(QW) + 1;

    logic [BW-1:0] busy_cnt;
    logic          both_num;
    assign both_num = (num_cls == 3'd1) && (den_cls == 3'd1);

    // Counts consecutive busy cycles for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    assert_special_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !both_num) |=> (done && !busy));

    assert_normal_goes_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && both_num) |=> (busy && !done));

    assert_fixed_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(busy)) |-> (busy_cnt == BW'(QW - 1)));

    assert_hold_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(q_exp) && $stable(q_cls)));

    assert_normalized_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q_cls == 3'd1) |-> q_mant[QW-1]);

    assert_divzero_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_divzero) |-> (q_cls == 3'd2 && !flag_invalid));

    assert_invalid_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_invalid) |-> (q_cls == 3'd3 || q_cls == 3'd4));
endmodule

bind fpdiv_unit fpdiv_unit_chk #(.MANT_W(MANT_W), .GR_W(GR_W), .EXP_W(EXP_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .num_cls      (num_cls),
    .den_cls      (den_cls),
    .busy         (busy),
    .done         (done),
    .q_cls        (q_cls),
    .q_exp        (q_exp),
    .q_mant       (q_mant),
    .flag_invalid (flag_invalid),
    .flag_divzero (flag_divzero)
);

// File: tb/test_fpdiv_unit.sv
// Scoreboard bench: driver pushes reference results, monitor compares on done.
module test_fpdiv_unit;
    localparam int CLK_PERIOD = 10;
    localparam int MANT_W = 24;
    localparam int GR_W   = 2;
    localparam int EXP_W  = 10;
    localparam int QW     = MANT_W + GR_W;
    localparam int XW     = EXP_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] num_cls = '0, den_cls = '0;
    logic num_sign = 1'b0, den_sign = 1'b0;
    logic [EXP_W-1:0] num_exp = '0, den_exp = '0;
    logic [MANT_W-1:0] num_mant = '0, den_mant = '0;
    logic busy, done, q_sign, q_sticky, flag_invalid, flag_divzero;
    logic [2:0] q_cls;
    logic [XW-1:0] q_exp;
    logic [QW-1:0] q_mant;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [2:0]    cls;
        logic          sign;
        logic [XW-1:0] exp;
        logic [QW-1:0] mant;
        logic          sticky;
        logic          inv;
        logic          dz;
        string         tag;
    } item_t;

    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fpdiv_unit #(.MANT_W(MANT_W), .GR_W(GR_W), .EXP_W(EXP_W)) i_fpdiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .num_cls(num_cls), .num_sign(num_sign), .num_exp(num_exp), .num_mant(num_mant),
        .den_cls(den_cls), .den_sign(den_sign), .den_exp(den_exp), .den_mant(den_mant),
        .busy(busy), .done(done), .q_cls(q_cls), .q_sign(q_sign), .q_exp(q_exp),
        .q_mant(q_mant), .q_sticky(q_sticky),
        .flag_invalid(flag_invalid), .flag_divzero(flag_divzero)
    );

    function automatic logic is_nan(logic [2:0] c);
        return c == 3'd3 || c == 3'd4;
    endfunction

    // Reference result built from the requirement text.
    function automatic item_t model(logic [2:0] ac, logic as, int ae, logic [MANT_W-1:0] am,
                                    logic [2:0] bc, logic bs, int be, logic [MANT_W-1:0] bm);
        item_t r;
        longint nl, ql, rl;
        int e;
        r.sticky = 0; r.inv = 0; r.dz = 0; r.tag = "";
        r.cls = ac; r.sign = as; r.exp = XW'(ae); r.mant = {am, 2'b00};
        if (is_nan(ac) || is_nan(bc)) begin                     // R2
            r.inv = 1;
            if (!(ac > bc)) begin
                r.cls = bc; r.sign = bs; r.exp = XW'(be); r.mant = {bm, 2'b00};
            end
        end else if ((ac == 3'd2 || ac == 3'd0) && bc == ac) begin // R3
            r.inv = 1; r.cls = 3'd3; r.sign = 0; r.exp = '0; r.mant = {1'b1, {(QW-1){1'b0}}};
        end else if (ac == 3'd2 || ac == 3'd0) begin            // R4
        end else if (bc == 3'd2) begin                          // R5
            r.cls = 3'd0; r.sign = as ^ bs; r.exp = '0; r.mant = '0;
        end else if (bc == 3'd0) begin                          // R6
            r.cls = 3'd2; r.sign = as ^ bs; r.exp = '0; r.mant = '0; r.dz = 1;
        end else begin                                          // R8 R9 R10
            r.cls = 3'd1; r.sign = as ^ bs;
            if (am >= bm) begin e = ae - be;     nl = longint'(am) << (QW-1); end
            else          begin e = ae - be - 1; nl = longint'(am) << QW;     end
            ql = nl / longint'(bm);
            rl = nl % longint'(bm);
            r.exp = XW'(e); r.mant = ql[QW-1:0]; r.sticky = (rl != 0);
        end
        return r;
    endfunction

    // Monitor: pop and compare each result when done is seen.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_cmp++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R12 unexpected done: actual cls=%0d mant=%h expected no result", q_cls, q_mant);
            end else begin
                item_t x;
                x = sb.pop_front();
                if (q_cls !== x.cls || q_sign !== x.sign || q_exp !== x.exp || q_mant !== x.mant ||
                    q_sticky !== x.sticky || flag_invalid !== x.inv || flag_divzero !== x.dz) begin
                    n_bad++;
                    $display("FAIL %s actual cls=%0d s=%0b e=%h m=%h st=%0b inv=%0b dz=%0b expected cls=%0d s=%0b e=%h m=%h st=%0b inv=%0b dz=%0b",
                             x.tag, q_cls, q_sign, q_exp, q_mant, q_sticky, flag_invalid, flag_divzero,
                             x.cls, x.sign, x.exp, x.mant, x.sticky, x.inv, x.dz);
                end
            end
        end
    end

    // Driver: push expectation, pulse start, measure latency (R7, R11).
    task automatic issue(string tag, logic [2:0] ac, logic as, int ae, logic [MANT_W-1:0] am,
                         logic [2:0] bc, logic bs, int be, logic [MANT_W-1:0] bm, bit poke);
        item_t it;
        int lat;
        int want;
        it = model(ac, as, ae, am, bc, bs, be, bm);
        it.tag = tag;
        sb.push_back(it);
        want = (ac == 3'd1 && bc == 3'd1) ? QW : 1;
        @(negedge clk);
        num_cls = ac; num_sign = as; num_exp = EXP_W'(ae); num_mant = am;
        den_cls = bc; den_sign = bs; den_exp = EXP_W'(be); den_mant = bm;
        start = 1;
        @(negedge clk);
        start = 0;
        lat = 1;
        if (poke) begin
            // R12: a start with other operands mid-run must be ignored
            repeat (3) begin @(negedge clk); lat++; end
            num_cls = 3'd0; den_cls = 3'd0; num_mant = '1; den_mant = '0;
            start = 1;
            @(negedge clk); lat++;
            @(negedge clk); lat++;
            start = 0;
        end
        while (!done) begin @(negedge clk); lat++; end
        n_cmp++;
        if (lat != want) begin
            n_bad++;
            $display("FAIL %s latency R11/R7 actual %0d expected %0d", tag, lat, want);
        end
    endtask

    localparam logic [MANT_W-1:0] M1_0 = 24'h800000;
    localparam logic [MANT_W-1:0] M1_5 = 24'hC00000;
    localparam logic [MANT_W-1:0] MMAX = 24'hFFFFFF;

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [MANT_W-1:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        n_cmp++;                                                 // R1
        if (busy !== 0 || done !== 0 || flag_invalid !== 0 || flag_divzero !== 0 || q_cls !== 0) begin
            n_bad++;
            $display("FAIL R1 reset state actual busy=%0b done=%0b inv=%0b dz=%0b cls=%0d expected all 0",
                     busy, done, flag_invalid, flag_divzero, q_cls);
        end

        // Normal divisions: R8 R9 R10 R11
        issue("R8 R9 1.5/1.0", 3'd1, 0, 5, M1_5, 3'd1, 0, 2, M1_0, 0);
        issue("R8 R10 1.0/1.5 sticky", 3'd1, 1, -3, M1_0, 3'd1, 0, 4, M1_5, 0);
        issue("R9 equal mantissas", 3'd1, 1, 0, M1_5, 3'd1, 1, 0, M1_5, 0);
        issue("R9 max/min", 3'd1, 0, 100, MMAX, 3'd1, 1, -100, M1_0, 0);
        issue("R10 min/max", 3'd1, 0, -7, M1_0, 3'd1, 0, 9, MMAX, 0);
        lf = 24'hACE1B5;
        for (int i = 0; i < 8; i++) begin
            logic [MANT_W-1:0] a, b;
            lf = {lf[22:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
            a = lf | 24'h800000;
            lf = {lf[22:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
            b = lf | 24'h800000;
            issue("R9 R10 pattern", 3'd1, i[0], i * 13 - 40, a, 3'd1, i[1], 20 - i * 7, b, 0);
        end

        // R12: start pulse during iteration is ignored
        issue("R12 ignored start", 3'd1, 0, 1, 24'hA5A5A5, 3'd1, 1, -2, 24'hC3C3C3, 1);

        // NaN selection: R2
        issue("R2 snan vs qnan", 3'd4, 1, 3, 24'h900001, 3'd3, 0, 7, 24'hC00002, 0);
        issue("R2 qnan vs snan", 3'd3, 1, 3, 24'h900001, 3'd4, 0, 7, 24'hA00002, 0);
        issue("R2 qnan tie divisor", 3'd3, 1, 3, 24'h900001, 3'd3, 0, 7, 24'hC00003, 0);
        issue("R2 num/qnan", 3'd1, 0, 1, M1_5, 3'd3, 1, -5, 24'hE00000, 0);
        issue("R2 qnan/zero", 3'd3, 1, 9, 24'hC00001, 3'd0, 0, 0, 24'h0, 0);

        // R3 default NaN
        issue("R3 inf/inf", 3'd2, 0, 0, 24'h0, 3'd2, 1, 0, 24'h0, 0);
        issue("R3 zero/zero", 3'd0, 1, 0, 24'h0, 3'd0, 1, 0, 24'h0, 0);

        // R4 dividend returned
        issue("R4 inf/num", 3'd2, 1, 0, 24'h0, 3'd1, 0, 3, M1_5, 0);
        issue("R4 inf/zero", 3'd2, 0, 0, 24'h0, 3'd0, 1, 0, 24'h0, 0);
        issue("R4 zero/num", 3'd0, 1, 0, 24'h0, 3'd1, 0, 3, M1_5, 0);
        issue("R4 zero/inf", 3'd0, 0, 0, 24'h0, 3'd2, 1, 0, 24'h0, 0);

        // R5 and R6 with sign XOR
        issue("R5 num/inf", 3'd1, 1, 4, M1_5, 3'd2, 0, 0, 24'h0, 0);
        issue("R6 num/zero", 3'd1, 0, 4, M1_5, 3'd0, 1, 0, 24'h0, 0);
        issue("R6 neg/neg zero", 3'd1, 1, -4, MMAX, 3'd0, 1, 0, 24'h0, 0);

        // R7 back-to-back special then normal
        issue("R7 special after normal", 3'd1, 0, 0, M1_0, 3'd2, 0, 0, 24'h0, 0);
        issue("R8 normal after special", 3'd1, 0, 0, M1_0, 3'd1, 0, 0, MMAX, 0);

        repeat (4) @(negedge clk);
        n_cmp++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R11 missing results actual %0d pending expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule